// File: doc/BRIEF.md
# Accumulator Processor with Staged Register-Transfer Fetch

This block is a small multi-cycle processor. It keeps one accumulator as its only working register, and a single memory array holds both its program and its data. A program counter, an address register (MAR), a data register (MDR) and a current-instruction register (CIR) carry each instruction from memory to execution. The controller moves exactly one value between these registers on each clock. Four operations exist, and each of the first three takes a direct 12-bit address: LOAD copies a memory word into the accumulator, ADD adds a memory word into it, STORE writes the accumulator back to memory, and HALT stops the machine.

The memory is synchronous and single-ported. While reset is held, a preload port writes program and data words into it. The memory contents are not cleared by reset, so a later run can read what an earlier run left behind. The state machine walks through these states: FETCH_ADDR (MAR takes PC), FETCH_READ (MDR takes the addressed word), FETCH_IR (CIR takes MDR and PC advances), DECODE (selects the next state), EXEC_ADDR (MAR takes the operand field), EXEC_READ (MDR takes the operand word), EXEC_DONE (the accumulator is updated or memory is written) and HALTED. DECODE goes to EXEC_ADDR on a defined operation code and to HALTED otherwise. EXEC_ADDR goes to EXEC_READ for LOAD and ADD, and straight to EXEC_DONE for STORE. EXEC_DONE returns to FETCH_ADDR. HALTED has no exit except reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, carry, MAR, MDR and CIR clear, `halted` goes low, the program counter loads START_ADDR (default 100) and the state becomes FETCH_ADDR.
- R2: An instruction word is 16 bits: bits [15:12] hold the operation code (0 HALT, 1 LOAD, 2 ADD, 3 STORE) and bits [11:0] hold a word address. Fetch and decode take four clocks (FETCH_ADDR, FETCH_READ, FETCH_IR, DECODE), and no state performs more than one register transfer.
- R3: LOAD puts the word at its address into the accumulator on the seventh clock counted from the start of its fetch. The accumulator changes on no other clock.
- R4: ADD also completes on its seventh clock. It leaves (accumulator + word) mod 2^16 in the accumulator and the carry-out in `carry`. LOAD and STORE leave `carry` unchanged.
- R5: STORE writes the accumulator to its address on its sixth clock, skips the operand read and leaves the accumulator unchanged.
- R6: The program counter advances by one during FETCH_IR, so instructions run from consecutive addresses. Instructions and data share one memory, so a word that STORE writes can be read back by a later LOAD or ADD.
- R7: Operation code 0 or any code from 4 to 15 raises `halted` four clocks after its fetch begins. `halted` then stays high, the accumulator stays unchanged and no memory write occurs until reset.
- R8: With START_ADDR 100, words 2 at address 10 and 3 at address 11, the program LOAD 10, ADD 11, STORE 12 leaves 5 in the accumulator and 5 at address 12.
- R9: The preload port writes memory only while `rst` is high. A preload request while `rst` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also enables the preload port |
| ld_en | input | 1 | Preload write strobe, honoured only while `rst` is high |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word |
| halted | output | 1 | High while the controller sits in HALTED |
| acc | output | 16 | Accumulator value |
| carry | output | 1 | Carry-out of the most recent ADD |

## Verification
Counting from the first clock after reset is released, a LOAD or ADD result shows up at the accumulator after 7 clocks, a STORE finishes after 6, and `halted` rises 4 clocks after a HALT or undefined code is fetched. The bench adds these figures together for each program it runs. It samples two nanoseconds after the exact edge where a value should change, and for `halted` it also samples one edge earlier to confirm the flag has not risen too soon. Memory contents can only be seen through the accumulator, so writes, and the absence of writes, are checked by resetting the processor and running a LOAD or ADD of the address concerned.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_HALT  = 4'd0;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OP_ADD   = 4'd2;
    localparam logic [OP_W-1:0] OP_STORE = 4'd3;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_FETCH_IR,
        ST_DECODE,
        ST_EXEC_ADDR,
        ST_EXEC_READ,
        ST_EXEC_DONE,
        ST_HALTED
    } state_e;

    function automatic logic op_defined(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);
    endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    // Array write: preload during reset or STORE afterwards
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    // Read register: this is the memory data register
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[addr];
        end
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(we && re));                                               // R2

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] sum,
    output logic              cout
);
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b};
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output state_e          state,
    output logic            mar_from_pc,
    output logic            mem_rd,
    output logic            ir_ld,
    output logic            mar_from_ir,
    output logic            acc_ld,
    output logic            acc_add,
    output logic            mem_wr,
    output logic            halted
);
    state_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH_ADDR;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH_ADDR: nxt = ST_FETCH_READ;
            ST_FETCH_READ: nxt = ST_FETCH_IR;
            ST_FETCH_IR:   nxt = ST_DECODE;
            ST_DECODE:     nxt = op_defined(opcode) ? ST_EXEC_ADDR : ST_HALTED;
            ST_EXEC_ADDR:  nxt = (opcode == OP_STORE) ? ST_EXEC_DONE : ST_EXEC_READ;
            ST_EXEC_READ:  nxt = ST_EXEC_DONE;
            ST_EXEC_DONE:  nxt = ST_FETCH_ADDR;
            ST_HALTED:     nxt = ST_HALTED;
        endcase
    end

    // One transfer strobe per state
    always_comb begin
        mar_from_pc = 1'b0;
        mem_rd      = 1'b0;
        ir_ld       = 1'b0;
        mar_from_ir = 1'b0;
        acc_ld      = 1'b0;
        acc_add     = 1'b0;
        mem_wr      = 1'b0;
        halted      = 1'b0;
        unique case (state)
            ST_FETCH_ADDR: mar_from_pc = 1'b1;
            ST_FETCH_READ: mem_rd      = 1'b1;
            ST_FETCH_IR:   ir_ld       = 1'b1;
            ST_DECODE:     ;
            ST_EXEC_ADDR:  mar_from_ir = 1'b1;
            ST_EXEC_READ:  mem_rd      = 1'b1;
            ST_EXEC_DONE: begin
                acc_ld  = (opcode == OP_LOAD);
                acc_add = (opcode == OP_ADD);
                mem_wr  = (opcode == OP_STORE);
            end
            ST_HALTED:     halted      = 1'b1;
        endcase
    end

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_ADDR) |=> (state == ST_FETCH_READ));     // R2
    AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        $countones({mar_from_pc, mem_rd, ir_ld, mar_from_ir,
                    acc_ld, acc_add, mem_wr}) <= 1);                // R2
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTED) |=> (state == ST_HALTED));             // R7
    AST_UNDEF_HALTS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && !op_defined(opcode)) |=> halted);    // R7

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 16,
    parameter int START_ADDR = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic              halted,
    output logic [WORD_W-1:0] acc,
    output logic              carry
);
    localparam int OP_LSB = WORD_W - OP_W;
    localparam logic [ADDR_W-1:0] PC_RESET = ADDR_W'(START_ADDR);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] cir_q;
    logic [WORD_W-1:0] acc_q;
    logic              carry_q;
    logic [WORD_W-1:0] mdr;

    state_e state;
    logic   mar_from_pc, mem_rd, ir_ld, mar_from_ir;
    logic   acc_ld, acc_add, mem_wr, halted_w;

    logic [WORD_W-1:0] sum;
    logic              sum_c;

    logic              m_we;
    logic [ADDR_W-1:0] m_addr;
    logic [WORD_W-1:0] m_wdata;

    acc_cpu_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .opcode      (cir_q[WORD_W-1:OP_LSB]),
        .state       (state),
        .mar_from_pc (mar_from_pc),
        .mem_rd      (mem_rd),
        .ir_ld       (ir_ld),
        .mar_from_ir (mar_from_ir),
        .acc_ld      (acc_ld),
        .acc_add     (acc_add),
        .mem_wr      (mem_wr),
        .halted      (halted_w)
    );

    acc_cpu_alu #(.WORD_W(WORD_W)) u_alu (
        .a    (acc_q),
        .b    (mdr),
        .sum  (sum),
        .cout (sum_c)
    );

    // Preload path owns the port only while reset is held
    always_comb begin
        if (rst) begin
            m_we    = ld_en;
            m_addr  = ld_addr;
            m_wdata = ld_data;
        end else begin
            m_we    = mem_wr;
            m_addr  = mar_q;
            m_wdata = acc_q;
        end
    end

    acc_cpu_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (m_we),
        .re    (mem_rd),
        .addr  (m_addr),
        .wdata (m_wdata),
        .rdata (mdr)
    );

    // Register transfers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= PC_RESET;
            mar_q   <= '0;
            cir_q   <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (mar_from_pc) begin
                mar_q <= pc_q;
            end
            if (mar_from_ir) begin
                mar_q <= cir_q[ADDR_W-1:0];
            end
            if (ir_ld) begin
                cir_q <= mdr;
                pc_q  <= pc_q + 1'b1;
            end
            if (acc_ld) begin
                acc_q <= mdr;
            end
            if (acc_add) begin
                acc_q   <= sum;
                carry_q <= sum_c;
            end
        end
    end

    assign halted = halted_w;
    assign acc    = acc_q;
    assign carry  = carry_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_IR) |=> (pc_q == $past(pc_q) + 1'b1));   // R6
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_EXEC_DONE) |=> $stable(acc_q));                // R3
    AST_WRITE_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mar_q == cir_q[ADDR_W-1:0]));                   // R5
    AST_HALT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        halted_w |=> ($stable(acc_q) && !mem_wr));                  // R7

endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [11:0] ld_addr;
    logic [15:0] ld_data;
    logic        halted;
    logic [15:0] acc;
    logic        carry;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_cpu u0 (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .halted  (halted),
        .acc     (acc),
        .carry   (carry)
    );

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        step(2);
        // R1: reset state
        chk("R1 acc", acc, 16'h0);
        chk("R1 carry", carry, 1'b0);
        chk("R1 halted", halted, 1'b0);

        // R8 required program, extended by ADD 12 to read back address 12
        put(12'd10, 16'd2);
        put(12'd11, 16'd3);
        put(12'd12, 16'd0);
        put(12'd100, ins(4'd1, 12'd10));
        put(12'd101, ins(4'd2, 12'd11));
        put(12'd102, ins(4'd3, 12'd12));
        put(12'd103, ins(4'd2, 12'd12));
        put(12'd104, ins(4'd0, 12'd0));
        release_reset();
        step(6);  chk("R3 acc before load completes", acc, 16'h0);
        step(1);  chk("R3 load", acc, 16'd2);
        chk("R4 carry unchanged by load", carry, 1'b0);
        step(7);  chk("R8 acc after add", acc, 16'd5);
        chk("R4 carry no overflow", carry, 1'b0);
        step(6);  chk("R5 acc after store", acc, 16'd5);
        step(7);  chk("R6 shared memory, address 12 held 5", acc, 16'd10);
        step(3);  chk("R2 halted not early", halted, 1'b0);
        step(1);  chk("R7 halted", halted, 1'b1);
        step(20); chk("R7 halted sticky", halted, 1'b1);
        chk("R7 acc frozen", acc, 16'd10);

        // R1 again after a halted run
        hold_reset();
        #2;
        chk("R1 halted cleared", halted, 1'b0);
        chk("R1 acc cleared", acc, 16'h0);

        // R4 sweep of ADD operands, arithmetic expectation
        for (int i = 0; i < 18; i++) begin
            logic [15:0] a, b;
            logic [16:0] s;
            a = (i == 16) ? 16'hFFFF : (i == 17) ? 16'h8000 : 16'(i * 16'h1357);
            b = (i == 16) ? 16'h0001 : (i == 17) ? 16'h8000 : 16'(16'hF000 + i * 16'h0321);
            s = {1'b0, a} + {1'b0, b};
            hold_reset();
            put(12'd200, a);
            put(12'd201, b);
            put(12'd100, ins(4'd1, 12'd200));
            put(12'd101, ins(4'd2, 12'd201));
            put(12'd102, ins(4'd0, 12'd0));
            release_reset();
            step(7);  chk("R3 load sweep", acc, a);
            step(7);  chk("R4 sum sweep", acc, s[15:0]);
            chk("R4 carry sweep", carry, s[16]);
            step(3);  chk("R2 halt not early sweep", halted, 1'b0);
            step(1);  chk("R7 halt sweep", halted, 1'b1);
        end

        // R4 carry retained across LOAD and STORE
        hold_reset();
        put(12'd300, 16'hFFFF);
        put(12'd301, 16'h0001);
        put(12'd302, 16'h0005);
        put(12'd100, ins(4'd1, 12'd300));
        put(12'd101, ins(4'd2, 12'd301));
        put(12'd102, ins(4'd1, 12'd302));
        put(12'd103, ins(4'd3, 12'd303));
        put(12'd104, ins(4'd0, 12'd0));
        release_reset();
        step(14); chk("R4 wrap", acc, 16'h0);
        chk("R4 carry out", carry, 1'b1);
        step(7);  chk("R4 carry kept by load", carry, 1'b1);
        chk("R3 load after add", acc, 16'd5);
        step(6);  chk("R4 carry kept by store", carry, 1'b1);
        step(4);  chk("R5 store length, halt at 31", halted, 1'b1);

        // R7 HALT and every undefined code: halt, no later write
        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 3) continue;
            hold_reset();
            put(12'd20, 16'h1234 + 16'(op));
            put(12'd30, 16'h0042);
            put(12'd100, ins(4'd1, 12'd20));
            put(12'd101, {4'(op), 12'd30});
            put(12'd102, ins(4'd3, 12'd30));
            release_reset();
            step(7);  chk("R3 load before stop", acc, 16'h1234 + 16'(op));
            step(3);  chk("R7 not halted early", halted, 1'b0);
            step(1);  chk("R7 stop code halts", halted, 1'b1);
            step(12); chk("R7 acc kept", acc, 16'h1234 + 16'(op));
            hold_reset();
            put(12'd100, ins(4'd1, 12'd30));
            put(12'd101, ins(4'd0, 12'd0));
            release_reset();
            step(7);  chk("R7 no write after stop", acc, 16'h0042);
            step(4);  chk("R7 halt readback run", halted, 1'b1);
        end

        // R9 preload ignored outside reset
        hold_reset();
        put(12'd40, 16'h0007);
        put(12'd100, ins(4'd0, 12'd0));
        release_reset();
        step(4);  chk("R9 halted", halted, 1'b1);
        put(12'd40, 16'hBEEF);
        put(12'd100, ins(4'd1, 12'd40));
        hold_reset();
        put(12'd100, ins(4'd1, 12'd40));
        put(12'd101, ins(4'd0, 12'd0));
        release_reset();
        step(7);  chk("R9 preload ignored out of reset", acc, 16'h0007);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule